// File: doc/BRIEF.md
# Speculative Read Dispatch and Cancel Unit

This unit sits between the miss path of a CPU cluster and a coherent interconnect. Each incoming read carries a requester ID, a line address and a type code. The unit decides whether the read is latency-critical. A latency-critical read is sent to memory at once, while the cache levels are still checking their tags. Any other read waits for the combined tag result and is sent down the normal path only when every level misses.

A small history table of saturating counters predicts cache misses. It is indexed by line address bits and trained by every tag result. This table works alongside the read type in the critical decision. A speculative read can be withdrawn in two ways. The snoop-filter directory probe may report that the line is probably held in a bypassed cache level, or the tag check may report a hit before the read has been confirmed. In either case the unit sends a cancel notice to the memory side and a resolution code to the requester.

Up to NSPEC speculative reads can have a memory request outstanding at once. A latency-critical read that arrives while all of these slots are busy falls back to the normal path.

Top module: `spec_read_dispatch`

## Requirements
- R1: A read whose type code is 0 (demand load miss), 1 (instruction fetch miss) or 2 (page table walk) is issued speculatively, whatever the predictor says, as long as fewer than NSPEC entries are busy. The speculative request is `spec_valid` with the same ID and address.
- R2: The predictor holds 2^IXW two-bit counters, indexed by `addr[OFF+IXW-1:OFF]`, and each counter resets to 1. Every tag result updates the counter at the index of the stored address of that ID. A miss adds 1 and saturates at 3; a hit subtracts 1 and saturates at 0. A read of type code 3 to 7 is issued speculatively when its counter is 2 or 3 at request time.
- R3: At most NSPEC entries are busy. A speculative issue makes an entry busy. A cancel, or `done_valid` for that ID, frees it. A latency-critical read that arrives while NSPEC entries are busy is handled as a non-speculative read.
- R4: A directory answer of "present" for an open speculative read produces, one cycle later, `cancel_valid` with that ID and a resolution with code 1.
- R5: A directory answer of "absent" produces no output and leaves the read open, so that it can still be cancelled.
- R6: A tag hit for an open speculative read produces, one cycle later, a cancel and a resolution with code 2. A directory answer that arrives later for that ID is ignored.
- R7: A tag miss for an open speculative read produces a resolution with code 0 (speculation used) and no cancel. Any later directory answer for that ID is ignored.
- R8: A non-speculative read produces no output at request time. On a tag miss it produces, one cycle later, `norm_valid` with the stored ID and address and a resolution with code 3. On a tag hit it produces only a resolution with code 4.
- R9: While `rst` is high, every valid output is 0, no entry is busy and every predictor counter is 1.
- R10: Every output is registered and appears exactly one cycle after the input event that causes it. A tag result and a directory answer are never presented in the same cycle, and a request never reuses an ID that is still in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_id | input | IDW | Requester ID of the read |
| req_addr | input | AW | Byte address of the read |
| req_type | input | 3 | Read type code (0 to 2 are critical classes) |
| tag_valid | input | 1 | Combined tag check result strobe |
| tag_id | input | IDW | ID the tag result belongs to |
| tag_hit | input | 1 | 1 if any cache level holds the line |
| dir_valid | input | 1 | Directory probe answer strobe |
| dir_id | input | IDW | ID the directory answer belongs to |
| dir_present | input | 1 | 1 if the directory predicts the line is cached |
| done_valid | input | 1 | Memory completion strobe |
| done_id | input | IDW | ID of the completed memory read |
| spec_valid | output | 1 | Speculative memory request |
| spec_id | output | IDW | ID of the speculative request |
| spec_addr | output | AW | Address of the speculative request |
| norm_valid | output | 1 | Normal-path memory request |
| norm_id | output | IDW | ID of the normal request |
| norm_addr | output | AW | Address of the normal request |
| cancel_valid | output | 1 | Cancel notice for a speculative request |
| cancel_id | output | IDW | ID being cancelled |
| resolve_valid | output | 1 | Final resolution to the requester |
| resolve_id | output | IDW | ID being resolved |
| resolve_code | output | 3 | 0 used, 1 cancelled by directory, 2 cancelled by tag hit, 3 normal issue, 4 local hit |

## Verification
The hardest situation to reach is the slot limit. It needs NSPEC speculative reads held open at once, with none of them cancelled or completed. The bench issues that many demand-load reads in a row without sending any tag, directory or completion events. It then checks that the next critical read falls back to the normal path, and that freeing one slot lets the following read speculate again. Saturation of the counters is reached by sending long runs of misses and then hits to a single index. The bench follows the counter value read by read, so each prediction is checked.

// File: rtl/spec_rd_pkg.sv
package spec_rd_pkg;
  typedef enum logic [2:0] {
    RES_SPEC_USED  = 3'd0,
    RES_CANCEL_DIR = 3'd1,
    RES_CANCEL_TAG = 3'd2,
    RES_NORMAL     = 3'd3,
    RES_LOCAL_HIT  = 3'd4
  } res_code_e;

  localparam logic [2:0] LAST_CRIT_TYPE = 3'd2;

  function automatic logic type_is_critical(input logic [2:0] t);
    return t <= LAST_CRIT_TYPE;
  endfunction
endpackage

// File: rtl/spec_miss_predictor.sv
module spec_miss_predictor #(
  parameter int IXW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IXW-1:0] rd_idx,
  output logic           pred_miss,
  input  logic           train_en,
  input  logic [IXW-1:0] train_idx,
  input  logic           train_miss
);
  localparam int NENT = 1 << IXW;

  logic [1:0] ctr [NENT];

  assign pred_miss = ctr[rd_idx][1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) ctr[i] <= 2'd1;
    end else if (train_en) begin
      if (train_miss && ctr[train_idx] != 2'd3)
        ctr[train_idx] <= ctr[train_idx] + 2'd1;
      else if (!train_miss && ctr[train_idx] != 2'd0)
        ctr[train_idx] <= ctr[train_idx] - 2'd1;
    end
  end
endmodule

// File: rtl/spec_id_tracker.sv
module spec_id_tracker #(
  parameter int NID = 16,
  parameter int AW  = 16,
  localparam int IDW = $clog2(NID)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue_spec,
  input  logic           issue_pend,
  input  logic [IDW-1:0] req_id,
  input  logic [AW-1:0]  req_addr,
  input  logic           tag_valid,
  input  logic [IDW-1:0] tag_id,
  input  logic           tag_hit,
  input  logic           dir_valid,
  input  logic [IDW-1:0] dir_id,
  input  logic           dir_present,
  input  logic           done_valid,
  input  logic [IDW-1:0] done_id,
  output logic [NID-1:0] open_vec,
  output logic [NID-1:0] busy_vec,
  output logic [NID-1:0] pend_vec,
  output logic [AW-1:0]  tag_addr
);
  logic [AW-1:0] addr_mem [NID];

  always_ff @(posedge clk) begin
    if (issue_spec || issue_pend) addr_mem[req_id] <= req_addr;
  end
  assign tag_addr = addr_mem[tag_id];

  for (genvar i = 0; i < NID; i++) begin : g_ent
    logic open_q, busy_q, pend_q;
    logic hit_me, tag_me, dir_kill, done_me;

    assign tag_me   = tag_valid && tag_id == IDW'(i);
    assign hit_me   = tag_me && tag_hit && open_q;
    assign dir_kill = dir_valid && dir_id == IDW'(i) && dir_present && open_q;
    assign done_me  = done_valid && done_id == IDW'(i);

    always_ff @(posedge clk) begin
      if (rst) begin
        open_q <= 1'b0;
        busy_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (issue_spec && req_id == IDW'(i)) begin
        open_q <= 1'b1;
        busy_q <= 1'b1;
        pend_q <= 1'b0;
      end else if (issue_pend && req_id == IDW'(i)) begin
        pend_q <= 1'b1;
      end else begin
        if (tag_me) begin
          open_q <= 1'b0;
          pend_q <= 1'b0;
        end
        if (hit_me || dir_kill || done_me) begin
          open_q <= 1'b0;
          busy_q <= 1'b0;
        end
      end
    end

    assign open_vec[i] = open_q;
    assign busy_vec[i] = busy_q;
    assign pend_vec[i] = pend_q;
  end
endmodule

// File: rtl/spec_read_dispatch.sv
module spec_read_dispatch
  import spec_rd_pkg::*;
#(
  parameter int NID   = 16,
  parameter int NSPEC = 8,
  parameter int AW    = 16,
  parameter int OFF   = 6,
  parameter int IXW   = 4,
  localparam int IDW  = $clog2(NID)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [IDW-1:0] req_id,
  input  logic [AW-1:0]  req_addr,
  input  logic [2:0]     req_type,
  input  logic           tag_valid,
  input  logic [IDW-1:0] tag_id,
  input  logic           tag_hit,
  input  logic           dir_valid,
  input  logic [IDW-1:0] dir_id,
  input  logic           dir_present,
  input  logic           done_valid,
  input  logic [IDW-1:0] done_id,
  output logic           spec_valid,
  output logic [IDW-1:0] spec_id,
  output logic [AW-1:0]  spec_addr,
  output logic           norm_valid,
  output logic [IDW-1:0] norm_id,
  output logic [AW-1:0]  norm_addr,
  output logic           cancel_valid,
  output logic [IDW-1:0] cancel_id,
  output logic           resolve_valid,
  output logic [IDW-1:0] resolve_id,
  output logic [2:0]     resolve_code
);
  localparam int CNTW = $clog2(NID + 1);

  logic [NID-1:0]  open_vec, busy_vec, pend_vec;
  logic [AW-1:0]   tag_addr;
  logic [CNTW-1:0] busy_cnt;
  logic            pred_miss, critical, issue_spec, issue_pend;
  logic            t_open, t_pend, tag_cancel, dir_cancel;
  logic            res_v;
  res_code_e       res_c;

  spec_miss_predictor #(.IXW(IXW)) u_pred (
    .clk(clk), .rst(rst),
    .rd_idx(req_addr[OFF+IXW-1:OFF]), .pred_miss(pred_miss),
    .train_en(tag_valid), .train_idx(tag_addr[OFF+IXW-1:OFF]),
    .train_miss(!tag_hit)
  );

  spec_id_tracker #(.NID(NID), .AW(AW)) u_trk (
    .clk(clk), .rst(rst),
    .issue_spec(issue_spec), .issue_pend(issue_pend),
    .req_id(req_id), .req_addr(req_addr),
    .tag_valid(tag_valid), .tag_id(tag_id), .tag_hit(tag_hit),
    .dir_valid(dir_valid), .dir_id(dir_id), .dir_present(dir_present),
    .done_valid(done_valid), .done_id(done_id),
    .open_vec(open_vec), .busy_vec(busy_vec), .pend_vec(pend_vec),
    .tag_addr(tag_addr)
  );

  assign busy_cnt   = CNTW'($countones(busy_vec));
  assign critical   = type_is_critical(req_type) || pred_miss;
  assign issue_spec = req_valid && critical && (busy_cnt < CNTW'(NSPEC));
  assign issue_pend = req_valid && !issue_spec;

  assign t_open     = open_vec[tag_id];
  assign t_pend     = pend_vec[tag_id];
  assign tag_cancel = tag_valid && tag_hit && t_open;
  assign dir_cancel = dir_valid && dir_present && open_vec[dir_id];

  always_comb begin
    res_v = 1'b1;
    res_c = RES_SPEC_USED;
    if (tag_valid && t_open)      res_c = tag_hit ? RES_CANCEL_TAG : RES_SPEC_USED;
    else if (tag_valid && t_pend) res_c = tag_hit ? RES_LOCAL_HIT : RES_NORMAL;
    else if (dir_cancel)          res_c = RES_CANCEL_DIR;
    else                          res_v = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_valid    <= 1'b0;
      spec_id       <= '0;
      spec_addr     <= '0;
      norm_valid    <= 1'b0;
      norm_id       <= '0;
      norm_addr     <= '0;
      cancel_valid  <= 1'b0;
      cancel_id     <= '0;
      resolve_valid <= 1'b0;
      resolve_id    <= '0;
      resolve_code  <= '0;
    end else begin
      spec_valid    <= issue_spec;
      spec_id       <= req_id;
      spec_addr     <= req_addr;
      norm_valid    <= tag_valid && !tag_hit && t_pend;
      norm_id       <= tag_id;
      norm_addr     <= tag_addr;
      cancel_valid  <= tag_cancel || dir_cancel;
      cancel_id     <= tag_cancel ? tag_id : dir_id;
      resolve_valid <= res_v;
      resolve_id    <= (tag_valid && (t_open || t_pend)) ? tag_id : dir_id;
      resolve_code  <= res_c;
    end
  end
endmodule

// File: rtl/spec_read_dispatch_chk.sv
module spec_read_dispatch_chk #(
  parameter int NID   = 16,
  parameter int NSPEC = 8,
  parameter int IDW   = 4,
  parameter int CNTW  = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [IDW-1:0]  req_id,
  input logic [2:0]      req_type,
  input logic            tag_valid,
  input logic            tag_hit,
  input logic            dir_valid,
  input logic            dir_present,
  input logic            spec_valid,
  input logic [IDW-1:0]  spec_id,
  input logic            norm_valid,
  input logic            cancel_valid,
  input logic [IDW-1:0]  cancel_id,
  input logic            resolve_valid,
  input logic [IDW-1:0]  resolve_id,
  input logic [2:0]      resolve_code,
  input logic [CNTW-1:0] busy_cnt
);
  assert_busy_limit_R3: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= CNTW'(NSPEC));

  assert_crit_issue_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_type <= 3'd2 && busy_cnt < CNTW'(NSPEC))
      |=> (spec_valid && spec_id == $past(req_id)));

  assert_spec_from_req_R10: assert property (@(posedge clk) disable iff (rst)
    spec_valid |-> $past(req_valid));

  assert_norm_after_miss_R8: assert property (@(posedge clk) disable iff (rst)
    norm_valid |-> ($past(tag_valid && !tag_hit) && resolve_valid && resolve_code == 3'd3));

  assert_cancel_cause_R4: assert property (@(posedge clk) disable iff (rst)
    cancel_valid |-> $past((tag_valid && tag_hit) || (dir_valid && dir_present)));

  assert_cancel_code_R6: assert property (@(posedge clk) disable iff (rst)
    cancel_valid |-> (resolve_valid && resolve_id == cancel_id &&
                      (resolve_code == 3'd1 || resolve_code == 3'd2)));

  assert_absent_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (dir_valid && !dir_present && !tag_valid) |=> (!cancel_valid && !resolve_valid));
endmodule

bind spec_read_dispatch spec_read_dispatch_chk #(
  .NID(NID), .NSPEC(NSPEC), .IDW(IDW), .CNTW(CNTW)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_type(req_type),
  .tag_valid(tag_valid), .tag_hit(tag_hit), .dir_valid(dir_valid),
  .dir_present(dir_present), .spec_valid(spec_valid), .spec_id(spec_id),
  .norm_valid(norm_valid), .cancel_valid(cancel_valid), .cancel_id(cancel_id),
  .resolve_valid(resolve_valid), .resolve_id(resolve_id),
  .resolve_code(resolve_code), .busy_cnt(busy_cnt)
);

// File: tb/spec_read_dispatch_bench.sv
module spec_read_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NID = 16, NSPEC = 8, AW = 16, OFF = 6, IXW = 4;
  localparam int IDW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, tag_valid = 0, tag_hit = 0, dir_valid = 0, dir_present = 0, done_valid = 0;
  logic [IDW-1:0] req_id = '0, tag_id = '0, dir_id = '0, done_id = '0;
  logic [AW-1:0]  req_addr = '0;
  logic [2:0]     req_type = '0;
  logic spec_valid, norm_valid, cancel_valid, resolve_valid;
  logic [IDW-1:0] spec_id, norm_id, cancel_id, resolve_id;
  logic [AW-1:0]  spec_addr, norm_addr;
  logic [2:0]     resolve_code;

  spec_read_dispatch #(.NID(NID), .NSPEC(NSPEC), .AW(AW), .OFF(OFF), .IXW(IXW)) u_spec_read_dispatch (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
    .req_type(req_type), .tag_valid(tag_valid), .tag_id(tag_id), .tag_hit(tag_hit),
    .dir_valid(dir_valid), .dir_id(dir_id), .dir_present(dir_present),
    .done_valid(done_valid), .done_id(done_id), .spec_valid(spec_valid), .spec_id(spec_id),
    .spec_addr(spec_addr), .norm_valid(norm_valid), .norm_id(norm_id), .norm_addr(norm_addr),
    .cancel_valid(cancel_valid), .cancel_id(cancel_id), .resolve_valid(resolve_valid),
    .resolve_id(resolve_id), .resolve_code(resolve_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;

  // Reference state built from the requirements
  logic [1:0]    m_ctr  [1 << IXW];
  logic          m_open [NID];
  logic          m_busy [NID];
  logic          m_pend [NID];
  logic [AW-1:0] m_addr [NID];

  // Expected outputs for the next check
  logic e_sv, e_nv, e_cv, e_rv;
  logic [IDW-1:0] e_sid, e_nid, e_cid, e_rid;
  logic [AW-1:0]  e_saddr, e_naddr;
  logic [2:0]     e_rc;

  function automatic int busy_count();
    int n = 0;
    for (int i = 0; i < NID; i++) n += int'(m_busy[i]);
    return n;
  endfunction

  task automatic clear_exp();
    e_sv = 0; e_nv = 0; e_cv = 0; e_rv = 0;
    e_sid = '0; e_nid = '0; e_cid = '0; e_rid = '0;
    e_saddr = '0; e_naddr = '0; e_rc = '0;
  endtask

  task automatic compare(input string rq);
    logic bad;
    bad = (spec_valid !== e_sv) || (norm_valid !== e_nv) ||
          (cancel_valid !== e_cv) || (resolve_valid !== e_rv) ||
          (e_sv && (spec_id !== e_sid || spec_addr !== e_saddr)) ||
          (e_nv && (norm_id !== e_nid || norm_addr !== e_naddr)) ||
          (e_cv && cancel_id !== e_cid) ||
          (e_rv && (resolve_id !== e_rid || resolve_code !== e_rc));
    total++;
    if (bad) begin
      fails++;
      $display("FAIL %s actual: spec=%b/%0d/%h norm=%b/%0d/%h cancel=%b/%0d res=%b/%0d/%0d expected: spec=%b/%0d/%h norm=%b/%0d/%h cancel=%b/%0d res=%b/%0d/%0d",
        rq, spec_valid, spec_id, spec_addr, norm_valid, norm_id, norm_addr, cancel_valid, cancel_id,
        resolve_valid, resolve_id, resolve_code, e_sv, e_sid, e_saddr, e_nv, e_nid, e_naddr,
        e_cv, e_cid, e_rv, e_rid, e_rc);
    end
  endtask

  // Inputs are set at a falling edge; the registered result is sampled at the next falling edge (R10)
  task automatic step(input string rq);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; tag_valid = 0; dir_valid = 0; done_valid = 0;
    compare(rq);
  endtask

  task automatic do_req(input int id, input logic [AW-1:0] a, input logic [2:0] t, input string rq);
    logic [IXW-1:0] ix;
    ix = a[OFF+IXW-1:OFF];
    clear_exp();
    if ((t <= 3'd2 || m_ctr[ix] >= 2'd2) && busy_count() < NSPEC) begin
      e_sv = 1; e_sid = IDW'(id); e_saddr = a;
      m_open[id] = 1; m_busy[id] = 1; m_pend[id] = 0;
    end else begin
      m_pend[id] = 1;
    end
    m_addr[id] = a;
    req_valid = 1; req_id = IDW'(id); req_addr = a; req_type = t;
    step(rq);
  endtask

  task automatic do_tag(input int id, input logic hit, input string rq);
    logic [IXW-1:0] ix;
    ix = m_addr[id][OFF+IXW-1:OFF];
    clear_exp();
    if (m_open[id]) begin
      e_rv = 1; e_rid = IDW'(id); e_rc = hit ? 3'd2 : 3'd0;
      if (hit) begin e_cv = 1; e_cid = IDW'(id); m_busy[id] = 0; end
      m_open[id] = 0;
    end else if (m_pend[id]) begin
      e_rv = 1; e_rid = IDW'(id); e_rc = hit ? 3'd4 : 3'd3;
      if (!hit) begin e_nv = 1; e_nid = IDW'(id); e_naddr = m_addr[id]; end
      m_pend[id] = 0;
    end
    if (!hit && m_ctr[ix] != 2'd3) m_ctr[ix] = m_ctr[ix] + 2'd1;
    else if (hit && m_ctr[ix] != 2'd0) m_ctr[ix] = m_ctr[ix] - 2'd1;
    tag_valid = 1; tag_id = IDW'(id); tag_hit = hit;
    step(rq);
  endtask

  task automatic do_dir(input int id, input logic present, input string rq);
    clear_exp();
    if (present && m_open[id]) begin
      e_cv = 1; e_cid = IDW'(id); e_rv = 1; e_rid = IDW'(id); e_rc = 3'd1;
      m_open[id] = 0; m_busy[id] = 0;
    end
    dir_valid = 1; dir_id = IDW'(id); dir_present = present;
    step(rq);
  endtask

  task automatic do_done(input int id, input string rq);
    clear_exp();
    m_busy[id] = 0; m_open[id] = 0;
    done_valid = 1; done_id = IDW'(id);
    step(rq);
  endtask

  task automatic cycle_read(input int id, input logic [AW-1:0] a, input logic [2:0] t,
                            input logic hit, input string rq);
    do_req(id, a, t, rq);
    do_tag(id, hit, rq);
    if (m_busy[id]) do_done(id, rq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << IXW); i++) m_ctr[i] = 2'd1;
    for (int i = 0; i < NID; i++) begin
      m_open[i] = 0; m_busy[i] = 0; m_pend[i] = 0; m_addr[i] = '0;
    end
    repeat (3) @(negedge clk);
    clear_exp();
    compare("R9 outputs during reset");
    rst = 0;
    @(negedge clk);
    compare("R9 outputs after reset");

    // R1/R8: every type code, fresh counters (value 1)
    for (int t = 0; t < 8; t++) do_req(t, AW'(t << OFF) | AW'(t), 3'(t), "R1 R8 type sweep request");
    for (int t = 0; t < 8; t++) do_tag(t, 1'b0, "R7 R8 tag miss after type sweep");
    for (int t = 0; t < 3; t++) do_done(t, "R3 completion frees entry");

    // R2: counters at indices 0..7 are now 2, so a prefetch-class read speculates
    for (int k = 0; k < 8; k++) do_req(8 + k, AW'(k << OFF) | AW'(3), 3'd5, "R2 predicted miss speculates");
    for (int k = 0; k < 8; k++) do_tag(8 + k, 1'b1, "R6 tag hit cancels open read");
    do_dir(8, 1'b1, "R6 directory answer after tag cancel ignored");
    for (int k = 0; k < 8; k++) do_req(8 + k, AW'(k << OFF), 3'd6, "R2 counter back to 1 no speculation");
    for (int k = 0; k < 8; k++) do_tag(8 + k, k[0], "R8 non-speculative resolution");

    // R2: saturation at both ends on index 9
    for (int n = 0; n < 6; n++) cycle_read(0, AW'(9 << OFF), 3'd4, 1'b0, "R2 miss run toward 3");
    for (int n = 0; n < 6; n++) cycle_read(0, AW'(9 << OFF), 3'd4, 1'b1, "R2 hit run toward 0");
    for (int n = 0; n < 3; n++) cycle_read(0, AW'(9 << OFF), 3'd7, 1'b0, "R2 recover from 0");

    // R4/R5: directory absent then present
    do_req(1, AW'(16'h1234), 3'd0, "R1 demand read");
    do_dir(1, 1'b0, "R5 absent gives no output");
    do_dir(1, 1'b1, "R4 present cancels still-open read");
    do_tag(1, 1'b0, "R4 tag after directory cancel is quiet");
    do_req(2, AW'(16'h2280), 3'd1, "R1 ifetch read");
    do_dir(2, 1'b1, "R4 directory cancel");
    do_tag(2, 1'b1, "R4 tag hit after directory cancel is quiet");

    // R7: tag miss confirms, later directory ignored
    do_req(3, AW'(16'h3340), 3'd2, "R1 table walk read");
    do_tag(3, 1'b0, "R7 tag miss confirms speculation");
    do_dir(3, 1'b1, "R7 directory after confirm ignored");
    do_done(3, "R3 completion after confirm");

    // R3: fill all speculation slots
    for (int i = 0; i < NSPEC; i++) do_req(i, AW'((i + 1) << OFF), 3'd0, "R3 fill slots");
    do_req(8, AW'(16'h0A00), 3'd0, "R3 full table forces normal path");
    do_req(9, AW'(16'h0B00), 3'd1, "R3 still full");
    do_done(3, "R3 free one slot");
    do_req(10, AW'(16'h0C00), 3'd2, "R3 freed slot allows speculation");
    do_tag(8, 1'b0, "R3 R8 fallback read issues normally");
    do_tag(9, 1'b1, "R8 fallback read local hit");
    for (int i = 0; i < NSPEC; i++) if (i != 3) do_tag(i, 1'b0, "R7 drain confirmed");
    do_tag(10, 1'b1, "R6 drain cancel");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule